// File: doc/BRIEF.md
# Bit-Field Insert and Rotate Unit

This is a combinational execution unit for a 32-bit RISC datapath. It carries out two register-to-register operations. The first is a field insert. It takes the low-order bits of a source operand and merges them into a contiguous bit range of a destination operand. Every destination bit outside that range keeps its old value. The second is a right rotate by an immediate amount, so a byte can be brought down to bit 0 with no bits lost.

The unit receives the two operand values that the register file has already read, the raw instruction word and a valid strobe. It decodes the instruction word itself. In the same cycle it returns a result, a write-enable and a flag for an illegal field range. When write-enable is low, the result simply passes the destination operand through, so a consumer that ignores write-enable still leaves the register unchanged.

A typical use moves a byte from one word into another in two instructions. For example, rotating 0x8C2E5F1E right by 8 gives 0x1E8C2E5F. Inserting 8 bits of that value at bit 16 of 0x10AC32BB then yields 0x105F32BB.

Top module: `bitfield_unit`

## Requirements
- R1: Instruction word fields are: major opcode [31:26], source register [25:21], destination register [20:16], upper immediate `hi` [15:11], lower immediate `lo` [10:6], minor opcode [5:0]. With validIn high, major opcode 0x1F and minor opcode 0x04 (insert) with hi >= lo, result bits hi..lo equal source bits (hi-lo)..0 and writeEn is 1.
- R2: For a legal insert, every result bit outside hi..lo equals the same bit of the destination operand.
- R3: An insert with hi < lo raises illegalField, drives writeEn to 0, and returns the destination operand unchanged.
- R4: With major opcode 0x1F and minor opcode 0x02 (rotate), the result is the source operand rotated right by `lo` (0 to 31 places), and writeEn is 1. The `hi` field is ignored and never raises illegalField.
- R5: A rotate by 0 returns the source operand unchanged.
- R6: Any other major or minor opcode gives writeEn 0 and illegalField 0, and the result equals the destination operand.
- R7: With validIn low, writeEn and illegalField are 0 and the result equals the destination operand, whatever the instruction word holds.
- R8: An insert with hi=31 and lo=0 returns the whole source operand.
- R9: An insert with hi=23 and lo=16 equals (dst & 0xFF00FFFF) | (src[7:0] << 16). A rotate by 8 followed by such an insert moves byte 1 of one word into byte 2 of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| validIn | input | 1 | Instruction word and operands are meaningful |
| instrIn | input | 32 | Raw instruction word |
| srcVal | input | 32 | Value of the source register |
| dstVal | input | 32 | Old value of the destination register |
| resultOut | output | 32 | Value to write back (destination value when writeEn is 0) |
| writeEn | output | 1 | Result should be written to the destination register |
| illegalField | output | 1 | Insert named a field whose upper bound lies below its lower bound |

## Verification
Field-range checking and rotate decoding both read the same two immediate fields in the same cycle. A rotate word can therefore carry an upper immediate smaller than its lower one, which would mark an insert as illegal. The bench sends rotate words for all 32 amounts with a random `hi` field, including values below `lo`. It expects write-enable to stay high and the illegal flag to stay low. Every legal (hi, lo) pair of the insert is also swept against a bit-by-bit model of the field placement, so a range check that fires on the wrong opcode, or a mask that misses one end of the range, is reported with its requirement tag.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;
  localparam int XLEN = 32;
  localparam int SHW = $clog2(XLEN);
  localparam int OPW = 6;

  // Field positions inside the instruction word, derived from the widths
  localparam int FUNCT_LSB = 0;
  localparam int LO_LSB = FUNCT_LSB + OPW;
  localparam int HI_LSB = LO_LSB + SHW;
  localparam int RT_LSB = HI_LSB + SHW;
  localparam int RS_LSB = RT_LSB + SHW;
  localparam int MAJOR_LSB = RS_LSB + SHW;

  // Strobes handed from the decoder to the datapath
  typedef struct packed {
    logic doInsert;
    logic doRotate;
    logic badField;
    logic [SHW-1:0] fieldLo;
    logic [SHW-1:0] fieldHi;
  } ctrlStrobes_t;
endpackage

// File: rtl/bitfield_ctrl.sv
module bitfield_ctrl
  import bitfield_pkg::*;
#(
  parameter logic [OPW-1:0] MAJOR_OP = 6'h1F,
  parameter logic [OPW-1:0] INS_FUNCT = 6'h04,
  parameter logic [OPW-1:0] ROT_FUNCT = 6'h02
) (
  input  logic validIn,
  input  logic [XLEN-1:0] instrIn,
  output ctrlStrobes_t strobes
);
  logic [OPW-1:0] majorOp;
  logic [OPW-1:0] minorOp;
  logic [SHW-1:0] immHi;
  logic [SHW-1:0] immLo;
  logic [2*SHW-1:0] unusedRegFields;
  logic majorHit;

  assign majorOp = instrIn[MAJOR_LSB +: OPW];
  assign minorOp = instrIn[FUNCT_LSB +: OPW];
  assign immHi = instrIn[HI_LSB +: SHW];
  assign immLo = instrIn[LO_LSB +: SHW];
  // Register numbers are resolved by the register file, not here
  assign unusedRegFields = instrIn[RT_LSB +: 2*SHW];

  assign majorHit = validIn && (majorOp == MAJOR_OP);

  always_comb begin
    strobes = '0;
    strobes.fieldLo = immLo;
    strobes.fieldHi = immHi;
    strobes.doInsert = majorHit && (minorOp == INS_FUNCT);
    strobes.doRotate = majorHit && (minorOp == ROT_FUNCT);
    strobes.badField = strobes.doInsert && (immHi < immLo);
  end

  always_comb begin
    AST_ONE_OP: assert ($onehot0({strobes.doInsert, strobes.doRotate}))
      else $error("both operations decoded"); // R6
    AST_BAD_ONLY_INSERT: assert (!strobes.badField || strobes.doInsert)
      else $error("field error outside insert"); // R4
    AST_IDLE_NO_OP: assert (validIn || !(strobes.doInsert || strobes.doRotate))
      else $error("operation decoded without valid"); // R7
  end
endmodule

// File: rtl/bitfield_barrel.sv
module bitfield_barrel
  import bitfield_pkg::*;
#(
  parameter bit ROTATE_RIGHT = 1'b1
) (
  input  logic [XLEN-1:0] dataIn,
  input  logic [SHW-1:0] amount,
  output logic [XLEN-1:0] dataOut
);
  logic [XLEN-1:0] stage [SHW+1];

  assign stage[0] = dataIn;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [XLEN-1:0] moved;
    if (ROTATE_RIGHT) begin : g_rot
      assign moved = {stage[k][SH-1:0], stage[k][XLEN-1:SH]};
    end else begin : g_shl
      assign moved = {stage[k][XLEN-SH-1:0], {SH{1'b0}}};
    end
    assign stage[k+1] = amount[k] ? moved : stage[k];
  end

  assign dataOut = stage[SHW];
endmodule

// File: rtl/bitfield_mask.sv
module bitfield_mask
  import bitfield_pkg::*;
(
  input  logic [SHW-1:0] fieldLo,
  input  logic [SHW-1:0] fieldHi,
  output logic [XLEN-1:0] mask
);
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    localparam logic [SHW-1:0] IDX = SHW'(i);
    assign mask[i] = (IDX >= fieldLo) && (IDX <= fieldHi);
  end
endmodule

// File: rtl/bitfield_datapath.sv
module bitfield_datapath
  import bitfield_pkg::*;
(
  input  ctrlStrobes_t strobes,
  input  logic [XLEN-1:0] srcVal,
  input  logic [XLEN-1:0] dstVal,
  output logic [XLEN-1:0] resultOut,
  output logic writeEn,
  output logic illegalField
);
  logic [XLEN-1:0] fieldMask;
  logic [XLEN-1:0] srcShifted;
  logic [XLEN-1:0] srcRotated;
  logic [XLEN-1:0] merged;

  bitfield_mask mask_i (
    .fieldLo(strobes.fieldLo),
    .fieldHi(strobes.fieldHi),
    .mask(fieldMask)
  );

  bitfield_barrel #(.ROTATE_RIGHT(1'b0)) place_i (
    .dataIn(srcVal),
    .amount(strobes.fieldLo),
    .dataOut(srcShifted)
  );

  bitfield_barrel #(.ROTATE_RIGHT(1'b1)) rot_i (
    .dataIn(srcVal),
    .amount(strobes.fieldLo),
    .dataOut(srcRotated)
  );

  assign merged = (dstVal & ~fieldMask) | (srcShifted & fieldMask);

  always_comb begin
    resultOut = dstVal;
    writeEn = 1'b0;
    illegalField = 1'b0;
    if (strobes.doInsert) begin
      if (strobes.badField) begin
        illegalField = 1'b1;
      end else begin
        resultOut = merged;
        writeEn = 1'b1;
      end
    end else if (strobes.doRotate) begin
      resultOut = srcRotated;
      writeEn = 1'b1;
    end
  end

  always_comb begin
    AST_WE_NOT_ILLEGAL: assert (!(writeEn && illegalField))
      else $error("write with illegal field"); // R3
    AST_INS_KEEPS_OUTSIDE: assert (!(strobes.doInsert && !strobes.badField)
                                   || (((resultOut ^ dstVal) & ~fieldMask) == '0))
      else $error("insert touched bits outside field"); // R2
    AST_ROT_ZERO: assert (!(strobes.doRotate && strobes.fieldLo == '0) || resultOut == srcVal)
      else $error("zero rotate changed operand"); // R5
    AST_IDLE_PASSTHRU: assert (writeEn || resultOut == dstVal)
      else $error("result not passthrough when idle"); // R6
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bitfield_pkg::*;
#(
  parameter logic [OPW-1:0] MAJOR_OP = 6'h1F,
  parameter logic [OPW-1:0] INS_FUNCT = 6'h04,
  parameter logic [OPW-1:0] ROT_FUNCT = 6'h02
) (
  input  logic validIn,
  input  logic [31:0] instrIn,
  input  logic [31:0] srcVal,
  input  logic [31:0] dstVal,
  output logic [31:0] resultOut,
  output logic writeEn,
  output logic illegalField
);
  ctrlStrobes_t strobes;

  bitfield_ctrl #(
    .MAJOR_OP(MAJOR_OP),
    .INS_FUNCT(INS_FUNCT),
    .ROT_FUNCT(ROT_FUNCT)
  ) ctrl_i (
    .validIn(validIn),
    .instrIn(instrIn),
    .strobes(strobes)
  );

  bitfield_datapath dp_i (
    .strobes(strobes),
    .srcVal(srcVal),
    .dstVal(dstVal),
    .resultOut(resultOut),
    .writeEn(writeEn),
    .illegalField(illegalField)
  );
endmodule

// File: tb/bitfield_unit_tb.sv
module bitfield_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic validIn = 1'b0;
  logic [31:0] instrIn = '0;
  logic [31:0] srcVal = '0;
  logic [31:0] dstVal = '0;
  logic [31:0] resultOut;
  logic writeEn;
  logic illegalField;

  bitfield_unit dut_i (
    .validIn(validIn),
    .instrIn(instrIn),
    .srcVal(srcVal),
    .dstVal(dstVal),
    .resultOut(resultOut),
    .writeEn(writeEn),
    .illegalField(illegalField)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit doneFlag = 1'b0;

  logic [33:0] expQ[$];
  string tagQ[$];

  function automatic logic [31:0] mkWord(input logic [5:0] maj, input logic [4:0] hi,
                                         input logic [4:0] lo, input logic [5:0] fn);
    logic [4:0] rsN;
    logic [4:0] rtN;
    rsN = 5'($urandom);
    rtN = 5'($urandom);
    return {maj, rsN, rtN, hi, lo, fn};
  endfunction

  // Reference built from the requirements, bit by bit
  function automatic logic [33:0] refModel(input logic v, input logic [31:0] w,
                                           input logic [31:0] s, input logic [31:0] d);
    logic [31:0] res;
    logic we;
    logic ill;
    int hi;
    int lo;
    hi = int'(w[15:11]);
    lo = int'(w[10:6]);
    res = d;
    we = 1'b0;
    ill = 1'b0;
    if (v && w[31:26] == 6'h1F && w[5:0] == 6'h04) begin
      if (hi < lo) ill = 1'b1;
      else begin
        we = 1'b1;
        for (int i = lo; i <= hi; i++) res[i] = s[i-lo];
      end
    end else if (v && w[31:26] == 6'h1F && w[5:0] == 6'h02) begin
      we = 1'b1;
      for (int i = 0; i < 32; i++) res[i] = s[(i+lo)%32];
    end
    return {we, ill, res};
  endfunction

  task automatic drive(input logic v, input logic [31:0] w, input logic [31:0] s,
                       input logic [31:0] d, input logic [33:0] exp, input string tag);
    @(posedge clk);
    #1;
    validIn = v;
    instrIn = w;
    srcVal = s;
    dstVal = d;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic driveRef(input logic v, input logic [31:0] w, input logic [31:0] s,
                          input logic [31:0] d, input string tag);
    drive(v, w, s, d, refModel(v, w, s, d), tag);
  endtask

  // Monitor: pops one expected item per cycle, away from the driving edge
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      logic [33:0] exp;
      string tag;
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      testsRun++;
      if ({writeEn, illegalField, resultOut} !== exp) begin
        testsFailed++;
        $display("FAIL %s: got we=%0b ill=%0b res=%08h, expected we=%0b ill=%0b res=%08h",
                 tag, writeEn, illegalField, resultOut, exp[33], exp[32], exp[31:0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      testsFailed++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // Reset state: idle outputs pass the destination through (R7)
    dstVal = 32'hA5A5_0F0F;
    instrIn = {6'h1F, 10'h0, 5'd31, 5'd0, 6'h04};
    repeat (3) @(posedge clk);
    @(negedge clk);
    testsRun++;
    if (writeEn !== 1'b0 || illegalField !== 1'b0 || resultOut !== 32'hA5A5_0F0F) begin
      testsFailed++;
      $display("FAIL R7 reset: got we=%0b ill=%0b res=%08h, expected we=0 ill=0 res=a5a50f0f",
               writeEn, illegalField, resultOut);
    end
    rstN = 1'b1;

    // R9: worked byte move
    drive(1'b1, mkWord(6'h1F, 5'd0, 5'd8, 6'h02), 32'h8C2E5F1E, 32'h0, {2'b10, 32'h1E8C2E5F}, "R9_rotate");
    drive(1'b1, mkWord(6'h1F, 5'd23, 5'd16, 6'h04), 32'h1E8C2E5F, 32'h10AC32BB, {2'b10, 32'h105F32BB}, "R9_insert");
    for (int n = 0; n < 20; n++) begin
      logic [31:0] s;
      logic [31:0] d;
      s = $urandom;
      d = $urandom;
      drive(1'b1, mkWord(6'h1F, 5'd23, 5'd16, 6'h04), s, d,
            {2'b10, (d & 32'hFF00FFFF) | {8'h0, s[7:0], 16'h0}}, "R9_mask");
    end

    // R8: full width
    drive(1'b1, mkWord(6'h1F, 5'd31, 5'd0, 6'h04), 32'hDEADBEEF, 32'h12345678, {2'b10, 32'hDEADBEEF}, "R8_full");

    // R1/R2: every legal (hi, lo) pair
    for (int lo = 0; lo < 32; lo++) begin
      for (int hi = lo; hi < 32; hi++) begin
        driveRef(1'b1, mkWord(6'h1F, 5'(hi), 5'(lo), 6'h04), $urandom, $urandom, "R1_R2_insert");
      end
    end

    // R3: illegal ranges
    for (int n = 0; n < 40; n++) begin
      logic [4:0] lo;
      logic [4:0] hi;
      logic [31:0] d;
      lo = 5'($urandom_range(1, 31));
      hi = 5'($urandom_range(0, int'(lo) - 1));
      d = $urandom;
      drive(1'b1, mkWord(6'h1F, hi, lo, 6'h04), $urandom, d, {2'b01, d}, "R3_illegal");
    end

    // R4/R5: every rotate amount, hi field random (often below lo)
    for (int a = 0; a < 32; a++) begin
      for (int n = 0; n < 3; n++) begin
        driveRef(1'b1, mkWord(6'h1F, 5'($urandom), 5'(a), 6'h02), $urandom, $urandom,
                 (a == 0) ? "R5_rot0" : "R4_rotate");
      end
    end
    drive(1'b1, mkWord(6'h1F, 5'd3, 5'd0, 6'h02), 32'hCAFEF00D, 32'h0, {2'b10, 32'hCAFEF00D}, "R5_rot0_fixed");

    // R6: other opcodes
    for (int n = 0; n < 60; n++) begin
      logic [5:0] maj;
      logic [5:0] fn;
      logic [31:0] d;
      maj = (n % 2 == 0) ? 6'h1F : 6'($urandom);
      fn = 6'($urandom);
      if (maj == 6'h1F && (fn == 6'h04 || fn == 6'h02)) fn = 6'h3F;
      d = $urandom;
      drive(1'b1, mkWord(maj, 5'($urandom), 5'($urandom), fn), $urandom, d, {2'b00, d}, "R6_other");
    end

    // R7: valid low with live instruction words
    for (int n = 0; n < 20; n++) begin
      logic [31:0] d;
      d = $urandom;
      drive(1'b0, mkWord(6'h1F, 5'd31, 5'd0, (n % 2 == 0) ? 6'h04 : 6'h02), $urandom, d, {2'b00, d}, "R7_novalid");
    end

    // Fully random words
    for (int n = 0; n < 300; n++) begin
      logic [5:0] fn;
      fn = (n % 3 == 0) ? 6'h04 : ((n % 3 == 1) ? 6'h02 : 6'($urandom));
      driveRef(1'($urandom), mkWord((n % 5 == 0) ? 6'($urandom) : 6'h1F, 5'($urandom), 5'($urandom), fn),
               $urandom, $urandom, "R1_R4_random");
    end

    @(posedge clk);
    #1;
    validIn = 1'b0;
    repeat (3) @(posedge clk);
    doneFlag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule